// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Synthesizer

This block stands in for a low-frequency proximity tag that answers a reader with two-frequency FSK. It takes a 44-bit identifier and produces a 1-bit coil-control level. It moves forward by exactly one sample on each rising edge of the reader carrier that reaches it on the `carrier` input. The level is 1 to open the coil and 0 to short it. The block never holds the waveform in memory. It tracks where it is inside the frame with a few small counters and works out every sample as it goes.

A frame is made of four parts, sent in this order:
- A single lone slow-pattern cycle.
- A start-of-frame marker built from eight half-bits. The marker deliberately contains pairs that are not valid bit codes.
- The identifier, sent MSB first. Each bit is coded as a pair of half-bits that use the two cycle shapes in opposite orders.
- One extra separator cycle in front of every group of four bits.

The frame repeats back to back for as long as `en` stays high. Pulling `en` low shorts the coil and rewinds the sequencer to the start of the frame.

Top module: `fsk_tag_synth`

## Requirements
- R1: There are two cycle shapes. The short cycle is 8 samples, written 11000000 (first sample first). The long cycle is 10 samples, written 1110000000.
- R2: A half-bit is either 6 short cycles (48 samples) or 5 long cycles (50 samples).
- R3: A data bit of 1 is a long-cycle half-bit followed by a short-cycle half-bit. A data bit of 0 is a short-cycle half-bit followed by a long-cycle half-bit.
- R4: Every frame opens with one lone short cycle (8 samples). Eight half-bits follow it as the marker, of types short, short, short, long, long, long, short, long.
- R5: The identifier bits are sent from `tag_id[43]` down to `tag_id[0]`.
- R6: Before each bit whose index modulo 4 equals 3 (bits 43, 39, …, 3), one separator short cycle (8 samples) is sent.
- R7: Each carrier rising edge seen while `en` is high advances the output by one sample. The output holds its value when there is no rising edge. A frame is 4800 samples long, and the next frame follows with no gap.
- R8: While `en` is low, `coil` is 0 and carrier edges have no effect. After `en` rises again, output resumes at sample 0 of a frame.
- R9: After reset, `coil` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the carrier rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables emulation; low shorts the coil and rewinds the frame |
| tag_id | input | 44 | Identifier to transmit, bit 43 first |
| carrier | input | 1 | Reader carrier, synchronous to `clk`; each rising edge steps one sample |
| coil | output | 1 | Coil control: 1 open, 0 shorted |

## Verification
A wrong internal state shows up at the ports within one carrier cycle, and never more than 10 samples later, as a sample that does not match.
- A phase counter that is off by one moves the point where the pattern drops from 1 to 0.
- A wrong half-bit count changes the length of a half-bit by a whole cycle.
- A wrong segment or bit index puts the long and short shapes in the wrong order. Every sample after that point is then offset.

Because of this, the bench compares every sample of whole frames against a model built from loops. It also covers a hold with no carrier edges, a disable in the middle of a frame, and a frame that repeats directly after the one before it.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

    // Segment of the frame being emitted
    typedef enum logic [1:0] {
        SEG_LEAD = 2'd0,
        SEG_SOF  = 2'd1,
        SEG_SEP  = 2'd2,
        SEG_BIT  = 2'd3
    } seg_e;

    localparam int SHORT_LEN = 8;
    localparam int LONG_LEN  = 10;
    localparam int SHORT_ON  = 2;
    localparam int LONG_ON   = 3;
    localparam int SHORT_REP = 6;
    localparam int LONG_REP  = 5;

endpackage

// File: rtl/fsk_cycle_gen.sv
module fsk_cycle_gen #(
    parameter int LO_LEN = 8,
    parameter int HI_LEN = 10,
    parameter int LO_ON  = 2,
    parameter int HI_ON  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic sel_hi,
    output logic level,
    output logic last
);
    localparam int PH_W = $clog2(HI_LEN);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        last  = sel_hi ? (st_q.phase == PH_W'(HI_LEN - 1))
                       : (st_q.phase == PH_W'(LO_LEN - 1));
        level = sel_hi ? (st_q.phase < PH_W'(HI_ON))
                       : (st_q.phase < PH_W'(LO_ON));
        st_d = st_q;
        if (clr) begin
            st_d.phase = '0;
        end else if (adv) begin
            st_d.phase = last ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !clr) |=> (st_q.phase == '0)); // R1

    AST_SHORT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hi |-> (st_q.phase < PH_W'(LO_LEN))); // R1

endmodule

// File: rtl/fsk_half_ctr.sv
module fsk_half_ctr #(
    parameter int LO_REP = 6,
    parameter int HI_REP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic cyc_last,
    input  logic sel_hi,
    input  logic active,
    output logic hb_last
);
    localparam int MAX_REP = (LO_REP > HI_REP) ? LO_REP : HI_REP;
    localparam int CNT_W   = $clog2(MAX_REP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        hb_last = active && cyc_last &&
                  (st_q.cnt == (sel_hi ? CNT_W'(HI_REP - 1) : CNT_W'(LO_REP - 1)));
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (adv && cyc_last) begin
            st_d.cnt = (hb_last || !active) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(MAX_REP)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cyc_last && !active) |=> (st_q.cnt == '0)); // R2

endmodule

// File: rtl/fsk_tag_synth.sv
module fsk_tag_synth
    import fsk_tag_pkg::*;
#(
    parameter int         ID_W    = 44,
    parameter int         GROUP   = 4,
    parameter int         SOF_LEN = 8,
    parameter logic [7:0] SOF_MAP = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [ID_W-1:0] tag_id,
    input  logic            carrier,
    output logic            coil
);
    localparam int BI_W   = $clog2(ID_W);
    localparam int SOF_IW = $clog2(SOF_LEN);

    typedef struct packed {
        seg_e              seg;
        logic [SOF_IW-1:0] sof_idx;
        logic [BI_W-1:0]   bit_idx;
        logic              half;
        logic              carrier_q;
        logic              coil_q;
    } top_st_t;

    top_st_t st_d, st_q;

    logic rise, adv, sel_hi, level, cyc_last, hb_last, hb_active;

    function automatic logic grp_first(input logic [BI_W-1:0] idx);
        return (int'(idx) % GROUP) == (GROUP - 1);
    endfunction

    fsk_cycle_gen #(
        .LO_LEN(SHORT_LEN), .HI_LEN(LONG_LEN),
        .LO_ON (SHORT_ON),  .HI_ON (LONG_ON)
    ) u_cycle (
        .clk(clk), .rst_n(rst_n), .clr(!en), .adv(adv),
        .sel_hi(sel_hi), .level(level), .last(cyc_last)
    );

    fsk_half_ctr #(
        .LO_REP(SHORT_REP), .HI_REP(LONG_REP)
    ) u_half (
        .clk(clk), .rst_n(rst_n), .clr(!en), .adv(adv),
        .cyc_last(cyc_last), .sel_hi(sel_hi), .active(hb_active),
        .hb_last(hb_last)
    );

    always_comb begin
        rise      = carrier && !st_q.carrier_q;
        adv       = en && rise;
        hb_active = (st_q.seg == SEG_SOF) || (st_q.seg == SEG_BIT);
        case (st_q.seg)
            SEG_SOF: sel_hi = SOF_MAP[st_q.sof_idx];
            SEG_BIT: sel_hi = tag_id[st_q.bit_idx] ^ st_q.half;
            default: sel_hi = 1'b0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.carrier_q = carrier;
        if (!en) begin
            st_d.seg     = SEG_LEAD;
            st_d.sof_idx = '0;
            st_d.bit_idx = BI_W'(ID_W - 1);
            st_d.half    = 1'b0;
            st_d.coil_q  = 1'b0;
        end else if (rise) begin
            st_d.coil_q = level;
            case (st_q.seg)
                SEG_LEAD: begin
                    if (cyc_last) begin
                        st_d.seg     = SEG_SOF;
                        st_d.sof_idx = '0;
                    end
                end
                SEG_SOF: begin
                    if (hb_last) begin
                        if (st_q.sof_idx == SOF_IW'(SOF_LEN - 1)) begin
                            st_d.bit_idx = BI_W'(ID_W - 1);
                            st_d.half    = 1'b0;
                            st_d.seg     = grp_first(BI_W'(ID_W - 1)) ? SEG_SEP : SEG_BIT;
                        end else begin
                            st_d.sof_idx = st_q.sof_idx + 1'b1;
                        end
                    end
                end
                SEG_SEP: begin
                    if (cyc_last) begin
                        st_d.seg  = SEG_BIT;
                        st_d.half = 1'b0;
                    end
                end
                default: begin
                    if (hb_last) begin
                        if (!st_q.half) begin
                            st_d.half = 1'b1;
                        end else if (st_q.bit_idx == '0) begin
                            st_d.seg     = SEG_LEAD;
                            st_d.half    = 1'b0;
                            st_d.bit_idx = BI_W'(ID_W - 1);
                        end else begin
                            st_d.bit_idx = st_q.bit_idx - 1'b1;
                            st_d.half    = 1'b0;
                            st_d.seg     = grp_first(st_q.bit_idx - 1'b1) ? SEG_SEP : SEG_BIT;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.seg     <= SEG_LEAD;
            st_q.bit_idx <= BI_W'(ID_W - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign coil = st_q.coil_q;

    AST_OFF_SHORTED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !coil); // R8

    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(carrier && !st_q.carrier_q)) |=> $stable(coil)); // R7

    AST_SEP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg == SEG_SEP) |-> grp_first(st_q.bit_idx)); // R6

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_idx < BI_W'(ID_W)); // R5

    AST_SOF_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg == SEG_SOF) |-> !st_q.half); // R4

endmodule

// File: tb/fsk_tag_synth_bench.sv
module fsk_tag_synth_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [43:0] tag_id;
    logic        carrier;
    logic        coil;
    int          n_chk = 0;
    int          n_err = 0;
    int          n_samp = 0;

    always #4 clk = ~clk;

    fsk_tag_synth u_fsk_tag_synth (
        .clk(clk), .rst_n(rst_n), .en(en), .tag_id(tag_id),
        .carrier(carrier), .coil(coil)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: sample %0d coil=%0b expected %0b", tag, n_samp, act, exp);
        end
    endtask

    // one carrier period: rising edge, then read the advanced sample (R7)
    task automatic step(input logic exp, input string tag);
        @(negedge clk); carrier = 1'b1;
        @(negedge clk); check(coil, exp, tag); carrier = 1'b0;
        n_samp++;
    endtask

    // R1: short cycle 11000000, long cycle 1110000000
    task automatic emit_cycle(input logic is_long, input string tag);
        int len = is_long ? 10 : 8;
        int on  = is_long ? 3 : 2;
        for (int k = 0; k < len; k++) step(k < on, tag);
    endtask

    // R2: six short or five long cycles
    task automatic emit_half(input logic is_long, input string tag);
        int reps = is_long ? 5 : 6;
        for (int r = 0; r < reps; r++) emit_cycle(is_long, tag);
    endtask

    // R4: lead cycle and marker
    task automatic emit_head();
        logic [7:0] kinds = 8'b1011_1000;
        emit_cycle(1'b0, "R1 R4 lead");
        for (int h = 0; h < 8; h++) emit_half(kinds[h], "R2 R4 sof");
    endtask

    // R3 R5 R6: bits MSB first with group separators
    task automatic emit_body(input logic [43:0] id);
        for (int b = 43; b >= 0; b--) begin
            if (b % 4 == 3) emit_cycle(1'b0, "R6 sep");
            emit_half(id[b],  "R3 R5 bit");
            emit_half(!id[b], "R3 R5 bit");
        end
    endtask

    task automatic emit_frame(input logic [43:0] id, input string note);
        int start = n_samp;
        emit_head();
        emit_body(id);
        n_chk++;
        if (n_samp - start != 4800) begin
            n_err++;
            $display("FAIL R7 %s: frame length %0d expected 4800", note, n_samp - start);
        end
    endtask

    initial begin
        int held;
        rst_n = 1'b0; en = 1'b0; carrier = 1'b0; tag_id = '0;
        repeat (3) @(negedge clk);
        check(coil, 1'b0, "R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(coil, 1'b0, "R9 after release");

        tag_id = 44'h9E3_5A71_C20B;
        en = 1'b1;
        emit_head();
        // R7: no carrier edges, output must hold
        held = coil;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check(coil, held[0], "R7 hold");
        end
        emit_body(tag_id);
        emit_frame(tag_id, "R7 repeat");

        // R8: disable mid-frame
        emit_head();
        @(negedge clk); en = 1'b0;
        @(negedge clk); check(coil, 1'b0, "R8 disabled");
        for (int p = 0; p < 4; p++) step(1'b0, "R8 edges ignored");
        tag_id = 44'hFFF_FFFF_FFFF;
        en = 1'b1;
        emit_frame(tag_id, "R8 restart ones");

        tag_id = 44'h000_0000_0000;
        emit_frame(tag_id, "zeros");
        tag_id = 44'h800_0000_0001;
        emit_frame(tag_id, "ends");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule